// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit single-precision floating-point operands and returns a rounded 32-bit sum. Each operand has a sign bit in bit 31, an 8-bit biased exponent in bits 30:23 (bias 127) and a 23-bit fraction in bits 22:0, with an implied leading one. Exponent code 0 marks a zero. Exponent code 255 is reserved, and operands that use it are outside the supported range.

The adder is a two-stage pipeline and accepts a new operand pair on every cycle. The first stage compares the magnitudes and shifts the smaller operand right by the exponent difference. It keeps guard, round and sticky bits during that shift, then adds or subtracts the significands. The second stage normalizes the result in either direction and rounds to nearest with ties to even. If rounding carries out of the significand, the second stage renormalizes. It then checks the exponent range and saturates to signed infinity or flushes to signed zero, setting the matching flag.

Top module: `fp32_add`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high for exactly one cycle, two rising edges later. `sum` then holds the correctly signed sum of the operands.
- R2: The operand with the smaller exponent is shifted right by the exponent difference before the add. A difference of 26 or more leaves the larger operand unchanged.
- R3: Rounding is round-to-nearest-even, based on the bits below the 24-bit significand. An exact half-way case rounds to the even fraction, and any nonzero bit beyond the guard bit breaks a tie upward.
- R4: If rounding carries out of the significand, the result becomes 1.0 × 2^(e+1).
- R5: A cancellation that leaves leading zeros is normalized by a left shift of as many positions as needed, and the exponent drops by the same amount.
- R6: A final exponent above 254 gives signed infinity: exponent field 0xFF and fraction 0. In that case `ovf` = 1 and `unf` = 0.
- R7: A nonzero result whose final exponent is below 1 is flushed to zero with the sign of the larger-magnitude operand. In that case `unf` = 1 and `ovf` = 0.
- R8: An exact zero produced by operands of opposite sign is +0 (0x00000000). The sum of two zeros of the same sign keeps that sign.
- R9: An operand with exponent field 0 is treated as zero, whatever its fraction bits.
- R10: While `rst_n` is low, `out_valid`, `sum`, `ovf` and `unf` are all 0.
- R11: Operand changes presented while `in_valid` is low have no effect. `out_valid` stays low, and `sum`, `ovf` and `unf` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands `a` and `b` are valid this cycle |
| a | input | 32 | First single-precision operand |
| b | input | 32 | Second single-precision operand |
| out_valid | output | 1 | `sum`, `ovf` and `unf` carry a new result |
| sum | output | 32 | Rounded single-precision sum |
| ovf | output | 1 | Result exceeded the largest normal exponent and was set to infinity |
| unf | output | 1 | Result fell below the smallest normal exponent and was flushed to zero |

## Verification
State is held only in the two pipeline registers. A corrupted alignment, sticky bit or leading-zero count shows up as a wrong `sum` on the `out_valid` cycle of the same operation, two edges after it is issued. A valid bit that is lost or stuck shows as a missing or extra `out_valid` pulse in the same window. Tie and sticky cases, a rounding carry, deep cancellation and both range limits are driven directly, so a slip of one bit in any shift or comparison changes a visible result.

// File: rtl/fp32_add.sv
module fp32_add (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic        out_valid,
  output logic [31:0] sum,
  output logic        ovf,
  output logic        unf
);
  localparam int EW   = 8;
  localparam int FW   = 23;
  localparam int MW   = FW + 1;
  localparam int XW   = MW + 3;
  localparam int WW   = 2 * MW + 2;
  localparam int EMAX = (1 << EW) - 2;

  // stage 1: order by magnitude, align, add
  logic [30:0]   mag_a, mag_b, big, sml;
  logic          swap, big_s, eff_sub;
  logic [EW-1:0] dexp;
  logic [MW-1:0] mb, ms;
  logic [WW-1:0] wide;
  logic [XW-1:0] al;
  logic [XW:0]   raw;

  assign mag_a   = (a[30:23] == '0) ? '0 : a[30:0];
  assign mag_b   = (b[30:23] == '0) ? '0 : b[30:0];
  assign swap    = mag_a < mag_b;
  assign big     = swap ? mag_b : mag_a;
  assign sml     = swap ? mag_a : mag_b;
  assign big_s   = swap ? b[31] : a[31];
  assign eff_sub = a[31] ^ b[31];
  assign dexp    = big[30:23] - sml[30:23];
  assign mb      = (big[30:23] == '0) ? '0 : {1'b1, big[22:0]};
  assign ms      = (sml[30:23] == '0) ? '0 : {1'b1, sml[22:0]};
  assign wide    = {ms, {(WW-MW){1'b0}}} >> dexp;
  assign al      = {wide[WW-1:MW], |wide[MW-1:0]};
  assign raw     = eff_sub ? {1'b0, mb, 3'b000} - {1'b0, al}
                           : {1'b0, mb, 3'b000} + {1'b0, al};

  logic          s1_v, s1_s, s1_sub;
  logic [EW-1:0] s1_e;
  logic [XW:0]   s1_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_s <= 1'b0; s1_sub <= 1'b0; s1_e <= '0; s1_sum <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_s <= big_s; s1_sub <= eff_sub; s1_e <= big[30:23]; s1_sum <= raw;
      end
    end
  end

  // stage 2: normalize, round, renormalize, range check
  logic [4:0]        lz;
  logic [XW-1:0]     nrm;
  logic signed [9:0] en, ef;
  logic              up;
  logic [MW:0]       rnd;
  logic [31:0]       res;
  logic              r_ovf, r_unf;

  always_comb begin
    lz = '0;
    for (int i = 0; i < XW; i++)
      if (s1_sum[i]) lz = 5'(XW - 1 - i);
    if (s1_sum[XW]) begin
      nrm = {s1_sum[XW:2], |s1_sum[1:0]};
      en  = $signed({2'b00, s1_e}) + 10'sd1;
    end else begin
      nrm = s1_sum[XW-1:0] << lz;
      en  = $signed({2'b00, s1_e}) - $signed({5'b0, lz});
    end
    up  = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
    rnd = {1'b0, nrm[XW-1:3]} + {{MW{1'b0}}, up};
    ef  = en + $signed({9'b0, rnd[MW]});
    r_ovf = 1'b0;
    r_unf = 1'b0;
    if (s1_sum == '0) begin
      res = {s1_s & ~s1_sub, 31'b0};
    end else if (ef > EMAX) begin
      res = {s1_s, {EW{1'b1}}, {FW{1'b0}}};
      r_ovf = 1'b1;
    end else if (ef < 10'sd1) begin
      res = {s1_s, 31'b0};
      r_unf = 1'b1;
    end else begin
      res = {s1_s, ef[EW-1:0], rnd[MW] ? {FW{1'b0}} : rnd[FW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; sum <= '0; ovf <= 1'b0; unf <= 1'b0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        sum <= res; ovf <= r_ovf; unf <= r_unf;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  p_exp_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ovf) |-> (sum[30:23] != 8'hFF));
  p_ovf_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ovf) |-> (sum[30:0] == 31'h7F800000 && !unf));
  p_unf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && unf) |-> (sum[30:0] == 31'h0 && !ovf));
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_v |=> ($stable(sum) && $stable(ovf) && $stable(unf)));
endmodule

// File: tb/fp32_add_tb.sv
module fp32_add_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 18;

  // {a, b, expected sum, ovf, unf}
  localparam logic [97:0] VEC [NV] = '{
    {32'h3F800000, 32'h40000000, 32'h40400000, 2'b00},  // R1 1+2
    {32'h3F800000, 32'hC0000000, 32'hBF800000, 2'b00},  // R1 1-2
    {32'h00000000, 32'h40400000, 32'h40400000, 2'b00},  // R1 0+3
    {32'h3F800000, 32'h0D800000, 32'h3F800000, 2'b00},  // R2 far shift
    {32'h3F000000, 32'hBEE00000, 32'h3D800000, 2'b00},  // R5 cancellation
    {32'h3F800000, 32'h33800000, 32'h3F800000, 2'b00},  // R3 tie, even kept
    {32'h3F800001, 32'h33800000, 32'h3F800002, 2'b00},  // R3 tie, odd up
    {32'h3F800000, 32'h33800001, 32'h3F800001, 2'b00},  // R3 sticky up
    {32'h3FFFFFFF, 32'h33800000, 32'h40000000, 2'b00},  // R4 round carry
    {32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 2'b10},  // R6 +inf
    {32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 2'b10},  // R6 -inf
    {32'h00800001, 32'h80800000, 32'h00000000, 2'b01},  // R7 +flush
    {32'h80800001, 32'h00800000, 32'h80000000, 2'b01},  // R7 -flush
    {32'h3F800000, 32'hBF800000, 32'h00000000, 2'b00},  // R8 x-x
    {32'hC0400000, 32'h40400000, 32'h00000000, 2'b00},  // R8 -x+x
    {32'h80000000, 32'h80000000, 32'h80000000, 2'b00},  // R8 -0+-0
    {32'h3F800000, 32'h00400000, 32'h3F800000, 2'b00},  // R9 denormal ignored
    {32'h00400000, 32'h80400000, 32'h00000000, 2'b00}   // R9 two denormals
  };
  localparam int VREQ [NV] = '{1,1,1,2,5,3,3,3,4,6,6,7,7,8,8,8,9,9};

  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        out_valid, ovf, unf;
  logic [31:0] sum;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  fp32_add dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
                  .out_valid(out_valid), .sum(sum), .ovf(ovf), .unf(unf));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, "R10 out_valid", {34'b0, out_valid}, '0);
    chk(sum == '0, "R10 sum", {3'b0, sum}, '0);
    chk({ovf, unf} == 2'b00, "R10 flags", {33'b0, ovf, unf}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: latency of exactly two edges, single pulse
    a = 32'h40000000; b = 32'h40000000; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid == 1'b0, "R1 no early valid", {34'b0, out_valid}, '0);
    @(negedge clk);
    chk(out_valid && sum == 32'h40800000, "R1 valid after two edges",
        {2'b0, out_valid, sum}, {3'b001, 32'h40800000});
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 single pulse", {34'b0, out_valid}, '0);

    for (int i = 0; i < NV; i++) begin
      a = VEC[i][97:66]; b = VEC[i][65:34]; in_valid = 1'b1;
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      chk(out_valid && sum == VEC[i][33:2] && {ovf, unf} == VEC[i][1:0],
          $sformatf("R%0d vector %0d", VREQ[i], i),
          {out_valid, sum, ovf, unf}, {1'b1, VEC[i][33:0]});
    end

    // R11: operands without in_valid are ignored
    a = 32'h7F7FFFFF; b = 32'h7F7FFFFF;
    repeat (3) @(negedge clk);
    chk(!out_valid && sum == 32'h00000000 && {ovf, unf} == 2'b00, "R11 idle operands ignored",
        {out_valid, sum, ovf, unf}, {1'b0, 32'h00000000, 2'b00});

    // R1: back-to-back operands
    a = 32'h3F800000; b = 32'h3F800000; in_valid = 1'b1;
    @(negedge clk); a = 32'h40400000; b = 32'h40A00000;
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid && sum == 32'h40000000, "R1 stream first",
        {2'b0, out_valid, sum}, {3'b001, 32'h40000000});
    @(negedge clk);
    chk(out_valid && sum == 32'h41000000, "R1 stream second",
        {2'b0, out_valid, sum}, {3'b001, 32'h41000000});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule